// File: doc/BRIEF.md
# Stack push/pop sequencer

This block owns the stack pointer of a processor core and turns stack commands into byte-addressed memory accesses. The stack grows toward lower addresses. A single push lowers the pointer by 2 or 4 and then stores the value at the new pointer. A single pop loads from the current pointer and then raises it by the same step. Values are little-endian: byte lane 0 of the data bus belongs at the address on the bus.

Besides the single-value commands, the block runs two multi-beat sequences. Save-all stores the eight general registers, and restore-all brings them back in reverse order. The restore skips the slot that holds the saved pointer. Popped values come back with a destination index, so the core's register file can write them.

The memory side is a simple request/ready port. A request is held until ready is seen high at a rising clock edge. While a command is in progress, busy is high and new commands are ignored.

Top module: `stack_sequencer`

## Requirements
- R1: After reset, busy, mem_we, mem_re and pop_valid are low and sp_out is zero.
- R2: Command code 9 loads sp_out from cmd_data on the edge that accepts it, makes no memory access and leaves busy low.
- R3: Command code 1 (16-bit push) lowers sp_out by 2 on the accepting edge and then writes cmd_data[15:0] at the new pointer, with mem_be = 4'b0011 and mem_wdata[31:16] zero. Byte lane 0 (mem_wdata[7:0]) is the byte at mem_addr.
- R4: Command code 2 (32-bit push of cmd_data) and code 3 (push of flags_in) lower sp_out by 4 and then write the full word at the new pointer, with mem_be = 4'b1111.
- R5: Command codes 4, 5 and 6 each make one read at sp_out; sp_out then rises by 2 for code 4 and by 4 for codes 5 and 6.
  - Code 4 returns mem_rdata[15:0] zero-extended; codes 5 and 6 return the full word.
  - pop_valid is high for one cycle, the cycle after the completing edge, with pop_dst equal to cmd_dst for codes 4 and 5 and equal to 8 for code 6.
- R6: mem_addr, mem_we, mem_re, mem_be and mem_wdata hold steady until mem_rdy is high at a rising edge; that edge completes the access.
- R7: A command is accepted only while busy is low. Busy is high from the cycle after acceptance until the cycle after the last completing edge. A command presented while busy has no effect on sp_out or on the accesses.
- R8: Command code 7 (save-all) makes eight 32-bit writes at descending addresses, each preceded by a pointer decrement of 4. They store register indices 0 to 7 in that order from regs_in (index i at bits 32*i+31:32*i), sampled at acceptance. Slot 4 stores the pointer as it was before the sequence, not regs_in slot 4.
- R9: Command code 8 (restore-all) makes eight 32-bit reads at ascending addresses for indices 7 down to 0. It delivers seven values with pop_dst = the index; the slot of index 4 is read but never delivered.
- R10: A complete save-all followed by a complete restore-all leaves sp_out at its value before the save-all.
- R11: Command codes 0 and 10 to 15 are ignored: no access, busy stays low, sp_out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 4 | Command code |
| cmd_data | input | 32 | Push value or new pointer |
| cmd_dst | input | 3 | Destination index for a single pop |
| flags_in | input | 32 | Flags word for code 3 |
| regs_in | input | 256 | Eight general registers, index i at bits 32*i+31:32*i |
| busy | output | 1 | Command in progress |
| sp_out | output | ADDR_W | Stack pointer |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_we | output | 1 | Write request |
| mem_re | output | 1 | Read request |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data, lane 0 at mem_addr |
| mem_rdata | input | 32 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Access completes at this edge |
| pop_valid | output | 1 | Popped value present |
| pop_dst | output | 4 | Destination index (8 = flags) |
| pop_data | output | 32 | Popped value |

## Verification
The hardest case to reach is a new command that arrives mid-sequence while memory is holding off ready. In that case the ignored command must leave neither the pointer nor the held request disturbed. The stimulus inserts random ready stalls on every access and presents a pointer-load command during one of those stalls. A second hard case is the save-all slot that holds the pointer rather than a register. To expose it, the register inputs are scrambled right after acceptance, and save-all/restore-all pairs run from many pointer values, including ones that are not word-aligned.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int REG_W = 32;
  localparam int REG_N = 8;
  localparam int LANES = REG_W / 8;
  localparam int SLOT_W = $clog2(REG_N);
  localparam int PTR_SLOT = 4;
  localparam logic [3:0] DST_FLAGS = 4'd8;

  localparam logic [3:0] OPC_PUSH_H  = 4'd1;
  localparam logic [3:0] OPC_PUSH_W  = 4'd2;
  localparam logic [3:0] OPC_PUSH_FL = 4'd3;
  localparam logic [3:0] OPC_POP_H   = 4'd4;
  localparam logic [3:0] OPC_POP_W   = 4'd5;
  localparam logic [3:0] OPC_POP_FL  = 4'd6;
  localparam logic [3:0] OPC_SAVE    = 4'd7;
  localparam logic [3:0] OPC_RESTORE = 4'd8;
  localparam logic [3:0] OPC_LOAD_SP = 4'd9;

  typedef struct packed {
    logic mem;
    logic write;
    logic wide;
    logic multi;
    logic flags;
    logic load_sp;
  } stk_dec_t;
endpackage

// File: rtl/stk_cmd_decode.sv
module stk_cmd_decode
  import stk_pkg::*;
(
  input  logic [3:0] op,
  output stk_dec_t   dec
);
  always_comb begin
    dec = '0;
    case (op)
      OPC_PUSH_H:  begin dec.mem = 1'b1; dec.write = 1'b1; end
      OPC_PUSH_W:  begin dec.mem = 1'b1; dec.write = 1'b1; dec.wide = 1'b1; end
      OPC_PUSH_FL: begin dec.mem = 1'b1; dec.write = 1'b1; dec.wide = 1'b1; dec.flags = 1'b1; end
      OPC_POP_H:   begin dec.mem = 1'b1; end
      OPC_POP_W:   begin dec.mem = 1'b1; dec.wide = 1'b1; end
      OPC_POP_FL:  begin dec.mem = 1'b1; dec.wide = 1'b1; dec.flags = 1'b1; end
      OPC_SAVE:    begin dec.mem = 1'b1; dec.write = 1'b1; dec.wide = 1'b1; dec.multi = 1'b1; end
      OPC_RESTORE: begin dec.mem = 1'b1; dec.wide = 1'b1; dec.multi = 1'b1; end
      OPC_LOAD_SP: begin dec.load_sp = 1'b1; end
      default:     dec = '0;
    endcase
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              dec_en,
  input  logic              inc_en,
  input  logic              step4,
  output logic [ADDR_W-1:0] sp
);
  localparam logic [ADDR_W-1:0] STEP_H = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_W = ADDR_W'(4);

  logic [ADDR_W-1:0] sp_q, sp_d, step;
  logic              sp_en;

  always_comb begin
    step  = step4 ? STEP_W : STEP_H;
    sp_en = load_en | dec_en | inc_en;
    if (load_en)     sp_d = load_val;
    else if (dec_en) sp_d = sp_q - step;
    else             sp_d = sp_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  assign sp = sp_q;

  assert_ptr_one_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_en, dec_en, inc_en}));
endmodule

// File: rtl/stk_lane.sv
module stk_lane
  import stk_pkg::*;
(
  input  logic             wide,
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] rd,
  output logic [REG_W-1:0] wr_data,
  output logic [LANES-1:0] be,
  output logic [REG_W-1:0] rd_data
);
  localparam int HALF = LANES / 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g < HALF) begin : g_low
      assign be[g] = 1'b1;
    end else begin : g_high
      assign be[g] = wide;
    end
    assign wr_data[8*g +: 8] = be[g] ? src[8*g +: 8] : 8'h00;
    assign rd_data[8*g +: 8] = be[g] ? rd[8*g +: 8]  : 8'h00;
  end
endmodule

// File: rtl/stack_sequencer.sv
module stack_sequencer
  import stk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [3:0]             cmd_op,
  input  logic [REG_W-1:0]       cmd_data,
  input  logic [2:0]             cmd_dst,
  input  logic [REG_W-1:0]       flags_in,
  input  logic [REG_N*REG_W-1:0] regs_in,
  output logic                   busy,
  output logic [ADDR_W-1:0]      sp_out,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_we,
  output logic                   mem_re,
  output logic [LANES-1:0]       mem_be,
  output logic [REG_W-1:0]       mem_wdata,
  input  logic [REG_W-1:0]       mem_rdata,
  input  logic                   mem_rdy,
  output logic                   pop_valid,
  output logic [3:0]             pop_dst,
  output logic [REG_W-1:0]       pop_data
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(REG_N - 1);
  localparam logic [SLOT_W-1:0] SKIP_BEAT = SLOT_W'(REG_N - 1 - PTR_SLOT);

  stk_dec_t dec;
  logic     accept, start, beat, last_beat, skip_beat;

  logic              act_q, act_d, write_q, write_d, wide_q, wide_d, multi_q, multi_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [REG_W-1:0]  val_q, val_d;
  logic [3:0]        dst_q, dst_d;
  logic              ctl_en;

  logic [REG_W-1:0]  cap_q [REG_N];
  logic              cap_en;

  logic              pv_q, pv_d;
  logic [3:0]        pdst_q, pdst_d;
  logic [REG_W-1:0]  pdata_q, rd_fmt, wr_src;

  logic              ptr_dec, ptr_inc, ptr_step4;
  logic [ADDR_W-1:0] sp;
  logic              unused_ptr_slot;

  assign unused_ptr_slot = ^regs_in[PTR_SLOT*REG_W +: REG_W];

  stk_cmd_decode u_dec (.op(cmd_op), .dec(dec));

  assign accept    = cmd_valid & ~act_q;
  assign start     = accept & dec.mem;
  assign beat      = act_q & mem_rdy;
  assign last_beat = ~multi_q | (slot_q == LAST_SLOT);
  assign skip_beat = multi_q & ~write_q & (slot_q == SKIP_BEAT);

  // control next state
  always_comb begin
    act_d   = act_q;
    write_d = write_q;
    wide_d  = wide_q;
    multi_d = multi_q;
    slot_d  = slot_q;
    val_d   = val_q;
    dst_d   = dst_q;
    ctl_en  = start | beat;
    if (start) begin
      act_d   = 1'b1;
      write_d = dec.write;
      wide_d  = dec.wide;
      multi_d = dec.multi;
      slot_d  = '0;
      val_d   = dec.flags ? flags_in : cmd_data;
      dst_d   = dec.flags ? DST_FLAGS : {1'b0, cmd_dst};
    end else if (beat) begin
      if (last_beat) act_d  = 1'b0;
      else           slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      multi_q <= 1'b0;
      slot_q  <= '0;
      val_q   <= '0;
      dst_q   <= '0;
    end else if (ctl_en) begin
      act_q   <= act_d;
      write_q <= write_d;
      wide_q  <= wide_d;
      multi_q <= multi_d;
      slot_q  <= slot_d;
      val_q   <= val_d;
      dst_q   <= dst_d;
    end
  end

  // register snapshot for save-all; the pointer slot holds the entry pointer
  assign cap_en = start & dec.multi & dec.write;
  for (genvar r = 0; r < REG_N; r++) begin : g_cap
    logic [REG_W-1:0] cap_d;
    if (r == PTR_SLOT) begin : g_sp
      assign cap_d = REG_W'(sp);
    end else begin : g_reg
      assign cap_d = regs_in[r*REG_W +: REG_W];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q[r] <= '0;
      else if (cap_en) cap_q[r] <= cap_d;
    end
  end

  // pointer control
  assign ptr_dec   = (start & dec.write) | (beat & write_q & ~last_beat);
  assign ptr_inc   = beat & ~write_q;
  assign ptr_step4 = start ? dec.wide : wide_q;

  stk_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (accept & dec.load_sp),
    .load_val(ADDR_W'(cmd_data)),
    .dec_en  (ptr_dec),
    .inc_en  (ptr_inc),
    .step4   (ptr_step4),
    .sp      (sp)
  );

  assign wr_src = multi_q ? cap_q[slot_q] : val_q;

  stk_lane u_lane (
    .wide   (wide_q),
    .src    (wr_src),
    .rd     (mem_rdata),
    .wr_data(mem_wdata),
    .be     (mem_be),
    .rd_data(rd_fmt)
  );

  // pop return
  always_comb begin
    pv_d   = beat & ~write_q & ~skip_beat;
    pdst_d = multi_q ? {1'b0, LAST_SLOT - slot_q} : dst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q    <= 1'b0;
      pdst_q  <= '0;
      pdata_q <= '0;
    end else begin
      pv_q <= pv_d;
      if (pv_d) begin
        pdst_q  <= pdst_d;
        pdata_q <= rd_fmt;
      end
    end
  end

  assign busy      = act_q;
  assign sp_out    = sp;
  assign mem_addr  = sp;
  assign mem_we    = act_q & write_q;
  assign mem_re    = act_q & ~write_q;
  assign pop_valid = pv_q;
  assign pop_dst   = pdst_q;
  assign pop_data  = pdata_q;

  assert_hold_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we | mem_re) & ~mem_rdy |=> (mem_we | mem_re) & $stable(mem_addr)
      & $stable(mem_we) & $stable(mem_be) & $stable(mem_wdata));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ~busy |-> ~mem_we & ~mem_re);

  assert_push_predec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) & mem_we |->
      sp_out == $past(sp_out) - ((mem_be == '1) ? ADDR_W'(4) : ADDR_W'(2)));

  assert_pop_postinc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re & mem_rdy |=>
      sp_out == $past(sp_out) + (($past(mem_be) == '1) ? ADDR_W'(4) : ADDR_W'(2)));

  assert_pop_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid |-> $past(mem_re & mem_rdy));

  assert_skip_ptr_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re & mem_rdy & multi_q & (slot_q == SKIP_BEAT) |=> ~pop_valid);
endmodule

// File: tb/stack_sequencer_bench.sv
`timescale 1ns/1ps
module stack_sequencer_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic [3:0]   cmd_op;
  logic [31:0]  cmd_data;
  logic [2:0]   cmd_dst;
  logic [31:0]  flags_in;
  logic [255:0] regs_in;
  logic         busy;
  logic [31:0]  sp_out, mem_addr;
  logic         mem_we, mem_re;
  logic [3:0]   mem_be;
  logic [31:0]  mem_wdata, mem_rdata;
  logic         mem_rdy;
  logic         pop_valid;
  logic [3:0]   pop_dst;
  logic [31:0]  pop_data;

  always #2.5 clk = ~clk;

  stack_sequencer u_stack_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_dst(cmd_dst), .flags_in(flags_in), .regs_in(regs_in),
    .busy(busy), .sp_out(sp_out), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy), .pop_valid(pop_valid), .pop_dst(pop_dst), .pop_data(pop_data)
  );

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0]  mem_m [0:4095];
  logic [31:0] m_sp;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {mem_m[12'(a + 3)], mem_m[12'(a + 2)], mem_m[12'(a + 1)], mem_m[12'(a)]};
  endfunction

  task automatic issue(input logic [3:0] op, input logic [31:0] d, input logic [2:0] dst);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_dst = dst;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'd0;
  endtask

  // one memory access with random ready stalls; optionally presents an
  // ignored pointer-load while busy (R7)
  task automatic access(input bit we, input logic [31:0] wdat, input logic [3:0] be,
                        input bit deliver, input logic [3:0] dst, input bit wide,
                        input bit poke, input int step_after);
    int w;
    logic [31:0] rv;
    w = poke ? $urandom_range(1, 3) : $urandom_range(0, 3);
    for (int c = 0; c < w; c++) begin
      mem_rdy = 1'b0;
      chk("R6", "request held", {30'd0, mem_we, mem_re}, {30'd0, we, ~we});
      chk("R6", "address held", mem_addr, m_sp);
      chk("R7", "busy in access", {31'd0, busy}, 32'd1);
      if (poke && c == 0) begin
        cmd_valid = 1'b1; cmd_op = 4'd9; cmd_data = 32'h0000_0124;
      end
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 4'd0;
    end
    chk(we ? "R4" : "R5", "strobe", {30'd0, mem_we, mem_re}, {30'd0, we, ~we});
    chk(we ? "R3" : "R5", "address", mem_addr, m_sp);
    chk(we ? "R3" : "R5", "byte enables", {28'd0, mem_be}, {28'd0, be});
    if (we) chk("R8", "write data", mem_wdata, wdat);
    rv = rd32(m_sp);
    if (!wide) rv = {16'h0, rv[15:0]};
    mem_rdata = rd32(m_sp);
    mem_rdy = 1'b1;
    if (we) for (int b = 0; b < 4; b++)
      if (be[b]) mem_m[12'(m_sp + b)] = wdat[8*b +: 8];
    @(negedge clk);
    mem_rdy = 1'b0;
    mem_rdata = $urandom();
    m_sp = m_sp + step_after;
    if (deliver) begin
      chk("R5", "pop_valid", {31'd0, pop_valid}, 32'd1);
      chk("R9", "pop_dst", {28'd0, pop_dst}, {28'd0, dst});
      chk("R5", "pop_data", pop_data, rv);
    end else begin
      chk("R9", "no pop", {31'd0, pop_valid}, 32'd0);
    end
    chk("R5", "pointer after access", sp_out, m_sp);
  endtask

  task automatic do_push(input int width, input bit flg, input logic [31:0] d);
    logic [31:0] v;
    flags_in = $urandom();
    v = flg ? flags_in : d;
    issue(flg ? 4'd3 : (width == 4 ? 4'd2 : 4'd1), d, 3'd0);
    m_sp = m_sp - width;
    chk(width == 4 ? "R4" : "R3", "pre-decrement", sp_out, m_sp);
    access(1'b1, width == 4 ? v : {16'h0, v[15:0]}, width == 4 ? 4'hF : 4'h3,
           1'b0, 4'd0, width == 4, $urandom_range(0, 1) == 1, 0);
    chk("R7", "busy released", {31'd0, busy}, 32'd0);
  endtask

  task automatic do_pop(input int width, input bit flg, input logic [2:0] dst);
    issue(flg ? 4'd6 : (width == 4 ? 4'd5 : 4'd4), $urandom(), dst);
    chk("R7", "busy after accept", {31'd0, busy}, 32'd1);
    access(1'b0, 32'd0, width == 4 ? 4'hF : 4'h3, 1'b1, flg ? 4'd8 : {1'b0, dst},
           width == 4, $urandom_range(0, 1) == 1, width);
    chk("R7", "busy released", {31'd0, busy}, 32'd0);
  endtask

  task automatic do_save();
    logic [31:0] start, v;
    logic [255:0] snap;
    for (int i = 0; i < 8; i++) regs_in[32*i +: 32] = $urandom();
    snap = regs_in;
    start = m_sp;
    issue(4'd7, 32'd0, 3'd0);
    regs_in = {$urandom(), $urandom(), $urandom(), $urandom(),
               $urandom(), $urandom(), $urandom(), $urandom()};
    m_sp = m_sp - 4;
    for (int k = 0; k < 8; k++) begin
      v = (k == 4) ? start : snap[32*k +: 32];
      access(1'b1, v, 4'hF, 1'b0, 4'd0, 1'b1, k == 2, k < 7 ? -4 : 0);
    end
    chk("R8", "busy released", {31'd0, busy}, 32'd0);
  endtask

  task automatic do_restore();
    issue(4'd8, 32'd0, 3'd0);
    for (int k = 0; k < 8; k++)
      access(1'b0, 32'd0, 4'hF, (7 - k) != 4, 4'(7 - k), 1'b1, k == 3, 4);
    chk("R9", "busy released", {31'd0, busy}, 32'd0);
  endtask

  task automatic do_load(input logic [31:0] v);
    issue(4'd9, v, 3'd0);
    m_sp = v;
    chk("R2", "pointer loaded", sp_out, v);
    chk("R2", "no busy", {31'd0, busy}, 32'd0);
    chk("R2", "no access", {30'd0, mem_we, mem_re}, 32'd0);
  endtask

  task automatic do_bad(input logic [3:0] op);
    issue(op, $urandom(), 3'd1);
    chk("R11", "no busy", {31'd0, busy}, 32'd0);
    chk("R11", "pointer kept", sp_out, m_sp);
    chk("R11", "no access", {30'd0, mem_we, mem_re}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    if (!done) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] s0;
    void'($urandom(32'd2718));
    for (int i = 0; i < 4096; i++) mem_m[i] = 8'(i ^ 8'h5A);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 4'd0; cmd_data = '0; cmd_dst = '0;
    flags_in = '0; regs_in = '0; mem_rdy = 1'b0; mem_rdata = '0; m_sp = '0;
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pointer after reset", sp_out, 32'd0);
    chk("R1", "strobes after reset", {30'd0, mem_we, mem_re}, 32'd0);
    chk("R1", "pop_valid after reset", {31'd0, pop_valid}, 32'd0);

    // directed corner cases
    do_load(32'h0000_0800);
    do_push(2, 1'b0, 32'h1234_BEEF);
    do_pop(2, 1'b0, 3'd5);
    do_push(4, 1'b0, 32'hCAFE_F00D);
    do_push(4, 1'b1, 32'd0);
    do_pop(4, 1'b1, 3'd0);
    do_pop(4, 1'b0, 3'd2);
    do_bad(4'd0);
    do_bad(4'd15);
    s0 = m_sp;
    do_save();
    do_restore();
    chk("R10", "pointer restored", sp_out, s0);
    do_load(32'h0000_0902);
    s0 = m_sp;
    do_save();
    do_restore();
    chk("R10", "pointer restored unaligned", sp_out, s0);

    // constrained random mix
    for (int n = 0; n < 120; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (m_sp < 32'h300 && r >= 3 && r <= 5) r = 1;
      if (m_sp < 32'h300 && r == 7) r = 6;
      if (m_sp > 32'hD00 && r <= 2) r = 4;
      if (m_sp > 32'hD00 && r == 6) r = 7;
      case (r)
        0: do_push(2, 1'b0, $urandom());
        1: do_push(4, 1'b0, $urandom());
        2: do_push(4, 1'b1, 32'd0);
        3: do_pop(2, 1'b0, 3'($urandom()));
        4: do_pop(4, 1'b0, 3'($urandom()));
        5: do_pop(4, 1'b1, 3'($urandom()));
        6: begin
          s0 = m_sp;
          do_save();
          if ($urandom_range(0, 1) == 1) begin
            do_restore();
            chk("R10", "pointer restored", sp_out, s0);
          end
        end
        7: do_restore();
        8: do_load({20'd0, 4'($urandom_range(4, 11)), 7'($urandom()), 1'b0});
        default: do_bad($urandom_range(0, 1) == 1 ? 4'd0 : 4'($urandom_range(10, 15)));
      endcase
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule